// File: doc/BRIEF.md
# Up/Down Capture Counter Timer

A 16-bit event counter that advances on rising edges of an external count input. A separate direction input selects the counting sense: low counts up and high counts down. An external clear input forces the count to zero while it is held high. A rising edge on an external capture input copies the running count into a holding register and produces a one-cycle capture interrupt. A wrap in either direction produces a one-cycle overflow interrupt.

All four external inputs are asynchronous to the system clock. Each one passes through a two-stage synchronizer, and edges are detected in the system clock domain. A processor reads the live count and the captured value from two output buses. It can also load the counter through a single-cycle write strobe with a data word.

Top module: `updown_capture_timer`

## Requirements
- R1: An external input change takes effect at the third rising system clock edge after it. The count and the interrupt outputs change at that edge and not earlier.
- R2: With the direction input low, each rising edge of the count input adds one to the count. A falling edge of the count input leaves the count unchanged.
- R3: With the direction input high, each rising edge of the count input subtracts one from the count.
- R4: Counting up from FFFFh gives 0000h, and counting down from 0000h gives FFFFh. Each such wrap raises the overflow interrupt for exactly one cycle. No other count step raises it.
- R5: A rising edge of the capture input loads the capture register with the count as it stood just before that edge takes effect. It also raises the capture interrupt for exactly one cycle.
- R6: The capture register keeps its value until the next rising capture edge. A falling capture edge and any counting leave it unchanged.
- R7: While the synchronized clear input is high, the count becomes 0000h and stays there. A count edge that arrives in the same cycle as the clear is lost and raises no overflow.
- R8: A write strobe loads the data word into the count at the next system clock edge. The write beats a count edge that lands in the same cycle, and the clear input beats the write.
- R9: After system reset, the count and the capture register are 0000h and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ext_clk_i | input | 1 | External count input, rising edge active |
| ext_clr_i | input | 1 | External clear input, active high level |
| dir_i | input | 1 | Direction: 0 counts up, 1 counts down |
| cap_i | input | 1 | Capture input, rising edge active |
| wr_en_i | input | 1 | Counter write strobe |
| wr_data_i | input | 16 | Value loaded by a write |
| count_o | output | 16 | Current count |
| capture_o | output | 16 | Captured count |
| ovf_irq_o | output | 1 | Overflow interrupt pulse |
| cap_irq_o | output | 1 | Capture interrupt pulse |

## Verification
The hardest cases to reach are collisions in a single cycle: a count edge meeting the clear, and a count edge meeting a processor write. Each event passes through its own synchronizer, so the stimulus changes the two pins on the same falling clock edge to line them up. For a write, the stimulus asserts the strobe exactly two cycles after raising the count input, so both land on the third edge. The wrap cases are reached by writing FFFEh or 0000h first, which avoids clocking the counter through 65536 edges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {CNT_UP = 1'b0, CNT_DOWN = 1'b1} dir_e;

  localparam int PIN_CLK = 0;
  localparam int PIN_CLR = 1;
  localparam int PIN_DIR = 2;
  localparam int PIN_CAP = 3;
  localparam int NUM_PINS = 4;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] sh_q;
    logic [STAGES:0] sh_d;

    always_comb sh_d = {sh_q[STAGES-1:0], pin_i[i]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end

    assign level_o[i] = sh_q[STAGES-1];
    assign rise_o[i]  = sh_q[STAGES-1] & ~sh_q[STAGES];
  end
endmodule

// File: rtl/updown_core.sv
module updown_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         tick_i,
  input  dir_e         dir_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] count_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         ovf_q, ovf_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    ovf_d  = 1'b0;
    cnt_en = clr_i | wr_en_i | tick_i;
    if (clr_i) begin
      cnt_d = '0;
    end else if (wr_en_i) begin
      cnt_d = wr_data_i;
    end else if (tick_i) begin
      if (dir_i == CNT_DOWN) begin
        cnt_d = cnt_q - 1'b1;
        ovf_d = (cnt_q == '0);
      end else begin
        cnt_d = cnt_q + 1'b1;
        ovf_d = (cnt_q == ALL_ONES);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/capture_unit.sv
module capture_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_rise_i,
  input  logic [W-1:0] count_i,
  output logic [W-1:0] capture_o,
  output logic         irq_o
);
  logic [W-1:0] hold_q;
  logic         irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (cap_rise_i) begin
      hold_q <= count_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= cap_rise_i;
  end

  assign capture_o = hold_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/updown_capture_timer.sv
module updown_capture_timer
  import tmr_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_clk_i,
  input  logic         ext_clr_i,
  input  logic         dir_i,
  input  logic         cap_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] capture_o,
  output logic         ovf_irq_o,
  output logic         cap_irq_o
);
  logic [NUM_PINS-1:0] pins, lvl, rise;
  logic                clr_sync;
  dir_e                dir_sync;

  always_comb begin
    pins          = '0;
    pins[PIN_CLK] = ext_clk_i;
    pins[PIN_CLR] = ext_clr_i;
    pins[PIN_DIR] = dir_i;
    pins[PIN_CAP] = cap_i;
  end

  pin_sync #(.N(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .level_o(lvl), .rise_o(rise)
  );

  assign clr_sync = lvl[PIN_CLR];
  assign dir_sync = dir_e'(lvl[PIN_DIR]);

  updown_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_sync), .tick_i(rise[PIN_CLK]),
    .dir_i(dir_sync), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .count_o(count_o), .ovf_o(ovf_irq_o)
  );

  capture_unit #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_rise_i(rise[PIN_CAP]), .count_i(count_o),
    .capture_o(capture_o), .irq_o(cap_irq_o)
  );
endmodule

// File: rtl/updown_capture_timer_chk.sv
module updown_capture_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr_sync,
  input logic         wr_en_i,
  input logic [W-1:0] wr_data_i,
  input logic [W-1:0] count_o,
  input logic [W-1:0] capture_o,
  input logic         ovf_irq_o,
  input logic         cap_irq_o
);
  // R4
  ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq_o |=> !ovf_irq_o);
  // R4
  ovf_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq_o |-> (count_o == '0 || count_o == {W{1'b1}}));
  // R5
  cap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq_o |=> !cap_irq_o);
  // R6
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_irq_o |-> $stable(capture_o));
  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sync |=> (count_o == '0 && !ovf_irq_o));
  // R8
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !clr_sync) |=> (count_o == $past(wr_data_i)));
endmodule

bind updown_capture_timer updown_capture_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_sync(clr_sync), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .count_o(count_o), .capture_o(capture_o),
  .ovf_irq_o(ovf_irq_o), .cap_irq_o(cap_irq_o)
);

// File: tb/updown_capture_timer_test.sv
module updown_capture_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk = 1'b0, ext_clr = 1'b0, dir = 1'b0, cap = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] count, capture;
  logic        ovf_irq, cap_irq;

  int checks = 0;
  int errors = 0;
  logic ovf_at, ovf_after, cap_at, cap_after;

  always #4 clk = ~clk;

  updown_capture_timer uut (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .ext_clr_i(ext_clr),
    .dir_i(dir), .cap_i(cap), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .count_o(count), .capture_o(capture), .ovf_irq_o(ovf_irq), .cap_irq_o(cap_irq)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  // count edge: rise, result at third system edge, then fall and settle
  task automatic tick();
    ext_clk = 1'b1;
    repeat (3) @(negedge clk);
    ovf_at = ovf_irq;
    @(negedge clk);
    ovf_after = ovf_irq;
    ext_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cap_pulse();
    cap = 1'b1;
    repeat (3) @(negedge clk);
    cap_at = cap_irq;
    @(negedge clk);
    cap_after = cap_irq;
    cap = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic write(input logic [15:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_dir(input logic d);
    dir = d;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(count == 16'h0, "R9 count", count, 16'h0);
    check(capture == 16'h0, "R9 capture", capture, 16'h0);
    check(!ovf_irq && !cap_irq, "R9 irqs", {14'h0, ovf_irq, cap_irq}, 16'h0);
  endtask

  task automatic t_latency();
    ext_clk = 1'b1;
    @(negedge clk);
    check(count == 16'h0, "R1 after edge 1", count, 16'h0);
    @(negedge clk);
    check(count == 16'h0, "R1 after edge 2", count, 16'h0);
    @(negedge clk);
    check(count == 16'h1, "R1 after edge 3", count, 16'h1);
    ext_clk = 1'b0;
    repeat (3) @(negedge clk);
    check(count == 16'h1, "R2 falling edge ignored", count, 16'h1);
  endtask

  task automatic t_up();
    for (int i = 0; i < 4; i++) tick();
    check(count == 16'h5, "R2 count up", count, 16'h5);
    check(!ovf_at, "R4 no ovf on plain step", {15'h0, ovf_at}, 16'h0);
  endtask

  task automatic t_down();
    set_dir(1'b1);
    tick(); tick();
    check(count == 16'h3, "R3 count down", count, 16'h3);
    set_dir(1'b0);
  endtask

  task automatic t_wrap_up();
    write(16'hFFFE);
    check(count == 16'hFFFE, "R8 write load", count, 16'hFFFE);
    tick();
    check(count == 16'hFFFF && !ovf_at, "R4 no ovf at FFFF", count, 16'hFFFF);
    tick();
    check(count == 16'h0, "R4 wrap up value", count, 16'h0);
    check(ovf_at && !ovf_after, "R4 ovf one cycle up", {14'h0, ovf_at, ovf_after}, 16'h2);
  endtask

  task automatic t_wrap_down();
    set_dir(1'b1);
    tick();
    check(count == 16'hFFFF, "R4 wrap down value", count, 16'hFFFF);
    check(ovf_at && !ovf_after, "R4 ovf one cycle down", {14'h0, ovf_at, ovf_after}, 16'h2);
    set_dir(1'b0);
  endtask

  task automatic t_capture();
    write(16'h1234);
    cap_pulse();
    check(capture == 16'h1234, "R5 captured value", capture, 16'h1234);
    check(cap_at && !cap_after, "R5 cap irq one cycle", {14'h0, cap_at, cap_after}, 16'h2);
    tick(); tick();
    check(capture == 16'h1234, "R6 hold while counting", capture, 16'h1234);
    cap = 1'b1;
    repeat (4) @(negedge clk);
    tick();
    cap = 1'b0;
    repeat (4) @(negedge clk);
    check(capture == 16'h1236 && !cap_irq, "R6 falling edge ignored", capture, 16'h1236);
    cap_pulse();
    check(capture == 16'h1237, "R5 second capture", capture, 16'h1237);
  endtask

  task automatic t_clear();
    write(16'h0040);
    ext_clr = 1'b1; ext_clk = 1'b1;
    repeat (3) @(negedge clk);
    check(count == 16'h0 && !ovf_irq, "R7 clear beats count edge", count, 16'h0);
    ext_clk = 1'b0;
    repeat (3) @(negedge clk);
    tick();
    check(count == 16'h0, "R7 held at zero", count, 16'h0);
    ext_clr = 1'b0;
    repeat (3) @(negedge clk);
    tick();
    check(count == 16'h1, "R7 counts after release", count, 16'h1);
  endtask

  task automatic t_collide();
    ext_clk = 1'b1;
    repeat (2) @(negedge clk);
    write(16'hABCD);
    check(count == 16'hABCD, "R8 write beats count edge", count, 16'hABCD);
    ext_clk = 1'b0;
    repeat (3) @(negedge clk);
    ext_clr = 1'b1;
    repeat (2) @(negedge clk);
    write(16'h5555);
    check(count == 16'h0, "R8 clear beats write", count, 16'h0);
    ext_clr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_latency();
    t_up();
    t_down();
    t_wrap_up();
    t_wrap_down();
    t_capture();
    t_clear();
    t_collide();
    summary();
  end
endmodule